// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block sits on the host side of a parallel flash device. It decides when an embedded program or erase inside the device has finished. A one-cycle `start` launches a polling run. The block then issues status reads at a fixed poll address through a simple request/acknowledge bus. It compares the bit-6 value of consecutive reads, and when that bit keeps changing it looks at the timeout flag on bit 5.

A run ends with a one-cycle `done` pulse and a `pass` flag. The flag stays valid until the next accepted start. On every failure the block first writes the device's return-to-read command, a single bus write whose address and data are parameters, and only then signals `done`. The host can leave polling with `abort`. The next `start` always begins again with a fresh pair of reads. An optional limit on the number of read pairs turns a device that never settles into a failure.

Top module: `tbpoll_ctrl`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `pass` and `bus_req` are all low.
- R2: A `start` seen while idle makes `busy` and `bus_req` high in the next cycle, with a read (`bus_we` low) at `POLL_ADDR`. A request holds its address, direction and write data until the cycle in which `bus_ack` is high. Read data is taken from `bus_rdata` in that cycle.
- R3: Each pair compares bit 6 of its two reads. If the values are equal, the run ends: `done` is high in the cycle after the acknowledge of the second read, `pass` is 1, and no write is issued.
- R4: If bit 6 differs within a pair and bit 5 of the second read is 0, the block starts another pair of reads. It does not raise `done`.
- R5: If bit 6 differs and bit 5 of the second read is 1, exactly two more reads follow. If their bit-6 values are equal, the run ends with `pass` = 1.
- R6: If bit 6 still differs in that re-check pair, the block issues one write of `RST_DATA` to `RST_ADDR`. `done` with `pass` = 0 follows in the cycle after that write's acknowledge.
- R7: `pass` holds its value from the end of a run until the next accepted `start`, which clears it.
- R8: A `start` while `busy` is high is ignored. The run in progress issues the same accesses and gives the same result.
- R9: `abort` while busy returns the block to idle in the next cycle with `bus_req` low and no `done`. It takes precedence over a same-cycle acknowledge. The next run begins with the first read of a new pair.
- R10: When `MAX_PAIRS` is non-zero, the `MAX_PAIRS`-th consecutive pair that toggles with bit 5 at 0 leads to the reset write and a fail result. A value of 0 removes the limit.
- R11: `done` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a polling run (taken only when idle) |
| abort | input | 1 | Leave polling immediately |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Access address |
| bus_wdata | output | DW | Write data |
| bus_ack | input | 1 | Access accepted this cycle |
| bus_rdata | input | DW | Read data, valid with `bus_ack` |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Result of the last run |

## Verification
The bench targets the re-check path. A design that treats a high bit 5 as immediate failure would report fail on a script whose re-check pair has settled. A design that reports success without the re-check would miss a device that is still toggling.

The abort case stops the run right after the first read of a pair. It then scripts the next run so that a design which resumed mid-pair, or compared against the stale stored bit, would take a different number of reads.

Random scripts with random acknowledge latency cover the pair limit and the exact cycle of `done`. A design that leaves out the reset write, or counts pairs off by one, changes the observed write count or read count.

// File: rtl/tbpoll_pkg.sv
package tbpoll_pkg;

    // Status bit positions the device drives during an embedded operation
    localparam int TGL_BIT = 6;
    localparam int TMO_BIT = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PAIR_A,
        ST_PAIR_B,
        ST_CHK_A,
        ST_CHK_B,
        ST_RST_WR
    } poll_st_e;

    typedef enum logic [1:0] {
        V_OK,
        V_AGAIN,
        V_RECHECK,
        V_FAIL
    } verdict_e;

    // Outcome of the second read of a pair
    function automatic verdict_e judge_pair(input logic first6, input logic cur6,
                                            input logic cur5, input logic in_recheck,
                                            input logic limit_hit);
        verdict_e v;
        if (first6 == cur6)    v = V_OK;
        else if (in_recheck)   v = V_FAIL;
        else if (cur5)         v = V_RECHECK;
        else if (limit_hit)    v = V_FAIL;
        else                   v = V_AGAIN;
        return v;
    endfunction

endpackage

// File: rtl/tbpoll_limit.sv
module tbpoll_limit #(
    parameter int MAX_PAIRS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic step,
    output logic last
);
    generate
        if (MAX_PAIRS == 0) begin : g_off
            assign last = 1'b0;
        end else begin : g_on
            localparam int CW = $clog2(MAX_PAIRS + 1);
            logic [CW-1:0] cnt;

            always_ff @(posedge clk) begin
                if (rst || clear) cnt <= '0;
                else if (step)    cnt <= cnt + 1'b1;
            end

            // High while the pair in flight is the final one allowed
            assign last = (cnt == CW'(MAX_PAIRS - 1));
        end
    endgenerate
endmodule

// File: rtl/tbpoll_fsm.sv
module tbpoll_fsm
    import tbpoll_pkg::*;
#(
    parameter int            DW        = 16,
    parameter int            AW        = 20,
    parameter logic [AW-1:0] POLL_ADDR = '0,
    parameter logic [AW-1:0] RST_ADDR  = '0,
    parameter logic [DW-1:0] RST_DATA  = DW'(16'h00F0)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          abort,
    input  logic          bus_ack,
    input  logic [DW-1:0] bus_rdata,
    input  logic          lim_last,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic          busy,
    output logic          done,
    output logic          pass,
    output logic          lim_clear,
    output logic          lim_step
);
    poll_st_e state;
    logic     first6;
    verdict_e verdict;
    logic     took;

    assign verdict = judge_pair(first6, bus_rdata[TGL_BIT], bus_rdata[TMO_BIT],
                                state == ST_CHK_B, lim_last);
    assign took    = bus_ack && !abort;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            first6 <= 1'b0;
            done   <= 1'b0;
            pass   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state == ST_IDLE) begin
                if (start) begin
                    state <= ST_PAIR_A;
                    pass  <= 1'b0;
                end
            end else if (abort) begin
                state <= ST_IDLE;
            end else if (bus_ack) begin
                unique case (state)
                    ST_PAIR_A: begin
                        first6 <= bus_rdata[TGL_BIT];
                        state  <= ST_PAIR_B;
                    end
                    ST_CHK_A: begin
                        first6 <= bus_rdata[TGL_BIT];
                        state  <= ST_CHK_B;
                    end
                    ST_PAIR_B, ST_CHK_B: begin
                        unique case (verdict)
                            V_OK: begin
                                state <= ST_IDLE;
                                done  <= 1'b1;
                                pass  <= 1'b1;
                            end
                            V_AGAIN:   state <= ST_PAIR_A;
                            V_RECHECK: state <= ST_CHK_A;
                            default:   state <= ST_RST_WR;
                        endcase
                    end
                    ST_RST_WR: begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                        pass  <= 1'b0;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        busy      = (state != ST_IDLE);
        bus_req   = busy;
        bus_we    = (state == ST_RST_WR);
        bus_addr  = bus_we ? RST_ADDR : POLL_ADDR;
        bus_wdata = bus_we ? RST_DATA : '0;
        lim_clear = (state == ST_IDLE) && start;
        lim_step  = (state == ST_PAIR_B) && took && (verdict == V_AGAIN);
    end
endmodule

// File: rtl/tbpoll_ctrl.sv
module tbpoll_ctrl #(
    parameter int            DW        = 16,
    parameter int            AW        = 20,
    parameter logic [AW-1:0] POLL_ADDR = '0,
    parameter logic [AW-1:0] RST_ADDR  = '0,
    parameter logic [DW-1:0] RST_DATA  = DW'(16'h00F0),
    parameter int            MAX_PAIRS = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          abort,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic          bus_ack,
    input  logic [DW-1:0] bus_rdata,
    output logic          busy,
    output logic          done,
    output logic          pass
);
    logic lim_clear, lim_step, lim_last;

    tbpoll_fsm #(
        .DW(DW), .AW(AW), .POLL_ADDR(POLL_ADDR),
        .RST_ADDR(RST_ADDR), .RST_DATA(RST_DATA)
    ) fsm_i (
        .clk(clk), .rst(rst), .start(start), .abort(abort),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .lim_last(lim_last),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .busy(busy), .done(done), .pass(pass),
        .lim_clear(lim_clear), .lim_step(lim_step)
    );

    tbpoll_limit #(.MAX_PAIRS(MAX_PAIRS)) lim_i (
        .clk(clk), .rst(rst), .clear(lim_clear),
        .step(lim_step), .last(lim_last)
    );
endmodule

// File: rtl/tbpoll_ctrl_chk.sv
module tbpoll_ctrl_chk #(
    parameter int DW = 16,
    parameter int AW = 20
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          abort,
    input logic          bus_req,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic          bus_ack,
    input logic          busy,
    input logic          done,
    input logic          pass
);
    logic wr_seen;

    always_ff @(posedge clk) begin
        if (rst)                                        wr_seen <= 1'b0;
        else if (start && !busy)                        wr_seen <= 1'b0;
        else if (bus_req && bus_we && bus_ack && !abort) wr_seen <= 1'b1;
    end

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !bus_req);

    a_r2_req_hold: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack && !abort) |=>
            (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

    a_r3_pass_no_write: assert property (@(posedge clk) disable iff (rst)
        (done && pass) |-> !wr_seen);

    a_r6_fail_after_write: assert property (@(posedge clk) disable iff (rst)
        (done && !pass) |-> wr_seen);

    a_r8_start_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !abort && !bus_ack) |=> busy);

    a_r9_abort_idle: assert property (@(posedge clk) disable iff (rst)
        (busy && abort) |=> (!busy && !done));

    a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

bind tbpoll_ctrl tbpoll_ctrl_chk #(.DW(DW), .AW(AW)) chk_i (
    .clk(clk), .rst(rst), .start(start), .abort(abort),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .busy(busy),
    .done(done), .pass(pass)
);

// File: tb/tbpoll_ctrl_tb_top.sv
module tbpoll_ctrl_tb_top;
    localparam int            DW   = 16;
    localparam int            AW   = 20;
    localparam int            BMAX = 4;
    localparam logic [AW-1:0] PA   = 20'h00010;
    localparam logic [AW-1:0] RA   = 20'h00AAA;
    localparam logic [DW-1:0] RD   = 16'h00F0;
    localparam int            SLEN = 40;

    logic          clk = 1'b0, rst = 1'b1, start = 1'b0, abort = 1'b0;
    logic          bus_req, bus_we, bus_ack = 1'b0, busy, done, pass;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata, bus_rdata = '0;

    tbpoll_ctrl #(.DW(DW), .AW(AW), .POLL_ADDR(PA), .RST_ADDR(RA),
                  .RST_DATA(RD), .MAX_PAIRS(BMAX)) dut_i (
        .clk(clk), .rst(rst), .start(start), .abort(abort),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .busy(busy), .done(done), .pass(pass)
    );

    always #4 clk = ~clk;

    int total = 0, bad = 0, cyc = 0;
    logic [DW-1:0] script [SLEN];
    int rd_idx = 0, wr_cnt = 0, done_cnt = 0, last_ret = 0, done_cyc = 0, wait_left = 0;
    logic ack_we = 1'b0, prev_done = 1'b0, clr_req = 1'b0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    // Device model and output monitor in one negedge process
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            chk(0, "watchdog", "cycles", cyc, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
        if (clr_req) begin
            rd_idx = 0; wr_cnt = 0; done_cnt = 0;
        end
        if (bus_ack) begin
            if (ack_we) wr_cnt++;
            else        rd_idx++;
            last_ret = cyc;
            bus_ack  = 1'b0;
        end
        if (done) begin
            done_cnt++;
            done_cyc = cyc;
        end
        if (done && prev_done) chk(0, "R11", "done width", 2, 1);
        prev_done = done;
        if (bus_req && !rst) begin
            if (wait_left == 0) begin
                bus_ack = 1'b1;
                ack_we  = bus_we;
                if (bus_we) begin
                    chk(bus_addr == RA, "R6", "write addr", int'(bus_addr), int'(RA));
                    chk(bus_wdata == RD, "R6", "write data", int'(bus_wdata), int'(RD));
                    bus_rdata = '0;
                end else begin
                    chk(bus_addr == PA, "R2", "read addr", int'(bus_addr), int'(PA));
                    bus_rdata = script[(rd_idx < SLEN) ? rd_idx : SLEN - 1];
                end
                wait_left = $urandom % 3;
            end else begin
                wait_left--;
            end
        end
    end

    // Expected outcome from the requirements
    function automatic void predict(output bit ok, output int nrd);
        int i = 0, pairs = 0;
        while (1) begin
            logic a6 = script[i][6], b6 = script[i+1][6], b5 = script[i+1][5];
            i += 2;
            if (a6 == b6) begin ok = 1; nrd = i; return; end
            if (b5) begin
                ok  = (script[i][6] == script[i+1][6]);
                nrd = i + 2;
                return;
            end
            pairs++;
            if (pairs == BMAX) begin ok = 0; nrd = i; return; end
        end
    endfunction

    task automatic fill_rand(input int p6, input int p5);
        for (int k = 0; k < SLEN; k++) begin
            script[k]    = DW'($urandom);
            script[k][6] = (($urandom % 100) < p6);
            script[k][5] = (($urandom % 100) < p5);
        end
    endtask

    task automatic put(input int k, input bit b6, input bit b5);
        script[k][6] = b6;
        script[k][5] = b5;
    endtask

    task automatic clear_model();
        clr_req = 1'b1;
        @(negedge clk);
        @(negedge clk);
        clr_req = 1'b0;
    endtask

    task automatic run(input string rq, input int busy_starts);
        bit ok; int nrd; int n;
        clear_model();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
        chk(pass == 1'b0, "R7", "pass cleared", int'(pass), 0);
        for (int s = 0; s < busy_starts; s++) begin
            start = 1'b1;
            @(negedge clk);
        end
        start = 1'b0;
        n = 0;
        while (!done && n < 400) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
        predict(ok, nrd);
        chk(n < 400, rq, "run ended", n, 0);
        chk(pass == ok, rq, "pass", int'(pass), int'(ok));
        chk(rd_idx == nrd, rq, "read count", rd_idx, nrd);
        chk(wr_cnt == (ok ? 0 : 1), rq, "reset writes", wr_cnt, ok ? 0 : 1);
        chk(done_cnt == 1, rq, "done pulses", done_cnt, 1);
        chk(done_cyc == last_ret, "R3", "done timing", done_cyc, last_ret);
    endtask

    initial begin
        for (int k = 0; k < SLEN; k++) script[k] = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !pass && !bus_req, "R1", "reset outputs",
            int'({busy, done, pass, bus_req}), 0);

        // R3: first pair equal
        fill_rand(0, 0); put(0, 1, 0); put(1, 1, 1);
        run("R3", 0);

        // R4: toggling pair with bit5 low, then settled pair
        fill_rand(0, 0); put(0, 0, 0); put(1, 1, 0); put(2, 1, 0); put(3, 1, 0);
        run("R4", 0);

        // R5: bit5 high, re-check settles
        fill_rand(0, 0); put(0, 0, 0); put(1, 1, 1); put(2, 0, 1); put(3, 0, 1);
        run("R5", 0);
        repeat (5) @(negedge clk);
        chk(pass == 1'b1, "R7", "pass held", int'(pass), 1);

        // R6: bit5 high, re-check still toggles
        fill_rand(0, 0); put(0, 0, 0); put(1, 1, 1); put(2, 0, 0); put(3, 1, 1);
        run("R6", 0);
        repeat (3) @(negedge clk);
        chk(pass == 1'b0, "R7", "fail held", int'(pass), 0);

        // R10: every pair toggles with bit5 low
        for (int k = 0; k < SLEN; k++) begin
            script[k] = DW'($urandom);
            put(k, k[0], 0);
        end
        run("R10", 0);

        // R8: start held while busy
        fill_rand(0, 0); put(0, 0, 0); put(1, 1, 0); put(2, 1, 0); put(3, 0, 0);
        put(4, 1, 0); put(5, 1, 0);
        run("R8", 3);

        // R9: abort right after the first read of a pair
        for (int k = 0; k < SLEN; k++) put(k, k[0], 0);
        clear_model();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int n = 0; n < 50 && rd_idx < 1; n++) @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        chk(!busy && !bus_req, "R9", "idle after abort", int'({busy, bus_req}), 0);
        repeat (5) @(negedge clk);
        chk(done_cnt == 0, "R9", "no done on abort", done_cnt, 0);
        fill_rand(0, 0); put(0, 1, 0); put(1, 1, 0); put(2, 0, 0); put(3, 0, 0);
        run("R9", 0);

        // Random scripts
        for (int t = 0; t < 30; t++) begin
            fill_rand(50, 30);
            run("R4", 0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        process::self().srandom(32'd1234);
    end
endmodule